// File: doc/BRIEF.md
# Receive Frame Statistics Analyzer

This block watches a byte-wide receive stream and sorts every frame it sees. Each beat has a valid flag, start and end markers and an error flag. The block checks the Ethernet CRC-32 as the bytes pass. It also pulls a 32-bit test sequence number from a fixed spot in the payload and compares it with the value it expects next. From these it infers frames that were lost, duplicated or delivered late.

Five saturating 32-bit counters hold the results. They can be read one at a time through a small address/data read port. A single clear pulse zeroes all five and restarts the sequence tracking. The block is meant to sit beside a MAC receive path in a traffic tester. Software reads the counters after a burst of generated test traffic.

Top module: `rx_stat_analyzer`

## Requirements
- R1: The total counter rises by one for every frame that ends (`in_valid` and `in_eof` high inside a frame), whether the frame is good or corrupted.
- R2: The sequence number is big-endian in frame bytes 14 to 17, the first four payload bytes after the 14-byte header. The first good frame after reset or clear sets the expected value to its number plus one and adds nothing to the drop counter.
- R3: A good frame whose number is above the expected value adds (number minus expected) to the drop counter, and the expected value becomes number plus one. A number equal to the expected value only advances the expected value.
- R4: A good frame whose number equals the expected value minus one (the last accepted number) adds one to the repeat counter and leaves the expected value unchanged. This test takes priority over R3.
- R5: A good frame whose number is below the expected value and is not a repeat adds one to the out-of-order counter and leaves the expected value unchanged.
- R6: A frame is corrupted when the CRC-32 run over all its bytes, including the FCS sent least significant byte first, misses the residue 0xDEBB20E3. A corrupted frame adds one to the corrupted counter only and does not touch sequence tracking.
- R7: A frame shorter than 64 bytes, FCS included, is classified as corrupted even when its CRC is right.
- R8: A frame with `in_err` high on any of its beats is classified as corrupted.
- R9: Every counter saturates at 0xFFFFFFFF instead of wrapping, including when a drop increment larger than one would overflow.
- R10: A one-cycle `clr` pulse zeroes all five counters and clears the sequence state. Clear wins over a frame result in the same cycle.
- R11: The read map places total at address 0, drop at 1, repeat at 2, out-of-order at 3 and corrupted at 4. Any other address reads zero. `rd_data` is registered and shows the counter for `rd_addr` one clock later.
- R12: Beats with `in_valid` low are ignored, and so are beats that arrive outside a frame (no start seen). Neither changes the CRC, the length or any counter.
- R13: After reset all counters read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | One-cycle pulse that zeroes the counters and the sequence state |
| in_valid | input | 1 | Receive beat is valid |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error on this beat |
| in_data | input | 8 | Receive byte |
| rd_addr | input | 3 | Counter select |
| rd_data | output | 32 | Selected counter value, registered |

## Verification
A wrong expected sequence value does not show up when it goes wrong. It appears at the ports only when the next good frame arrives, as a wrong split between the drop, repeat and out-of-order counters. The bench therefore reads every counter after every frame. The corrupted frames in its table are followed by good frames whose numbers would be classed differently if a bad frame had moved the expected value. A CRC or length fault changes the corrupted counter within three clocks of the last byte. Saturation faults appear only after enormous drop increments, so sequence jumps near the 32-bit limit drive the drop counter into its ceiling.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int NUM_CTR = 5;

  typedef enum logic [2:0] {
    CTR_TOTAL   = 3'd0,
    CTR_DROP    = 3'd1,
    CTR_REPEAT  = 3'd2,
    CTR_OOO     = 3'd3,
    CTR_CORRUPT = 3'd4
  } ctr_sel_e;

  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  // Reflected CRC-32 update, one byte, LSB first.
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_frame_parse.sv
module rx_frame_parse
  import rx_stat_pkg::*;
#(
  parameter int SEQ_W   = 32,
  parameter int SEQ_OFS = 14,
  parameter int MIN_LEN = 64,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_err,
  input  logic [7:0]       in_data,
  output logic             fd_valid,
  output logic             fd_good,
  output logic [SEQ_W-1:0] fd_seq
);
  localparam int SEQ_BYTES = SEQ_W / 8;
  localparam logic [LEN_W-1:0] SEQ_LO  = LEN_W'(SEQ_OFS);
  localparam logic [LEN_W-1:0] SEQ_HI  = LEN_W'(SEQ_OFS + SEQ_BYTES - 1);
  localparam logic [LEN_W-1:0] LAST_OK = LEN_W'(MIN_LEN - 1);

  logic             in_frame;
  logic [31:0]      crc_q;
  logic [LEN_W-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q;
  logic             err_q;

  logic             start, take;
  logic [31:0]      crc_nx;
  logic [LEN_W-1:0] idx_cur, idx_nx;
  logic [SEQ_W-1:0] seq_base, seq_nx;
  logic             err_nx;

  always_comb begin
    start    = in_valid && in_sof;
    take     = in_valid && (in_sof || in_frame);
    crc_nx   = crc32_byte(start ? CRC_INIT : crc_q, in_data);
    idx_cur  = start ? '0 : idx_q;
    idx_nx   = (idx_cur == '1) ? idx_cur : idx_cur + 1'b1;
    seq_base = start ? '0 : seq_q;
    seq_nx   = (idx_cur >= SEQ_LO && idx_cur <= SEQ_HI) ?
               {seq_base[SEQ_W-9:0], in_data} : seq_base;
    err_nx   = (start ? 1'b0 : err_q) | in_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      crc_q    <= CRC_INIT;
      idx_q    <= '0;
      seq_q    <= '0;
      err_q    <= 1'b0;
      fd_valid <= 1'b0;
      fd_good  <= 1'b0;
      fd_seq   <= '0;
    end else begin
      fd_valid <= 1'b0;
      if (take) begin
        crc_q <= crc_nx;
        idx_q <= idx_nx;
        seq_q <= seq_nx;
        err_q <= err_nx;
        if (in_eof) begin
          in_frame <= 1'b0;
          fd_valid <= 1'b1;
          fd_good  <= (crc_nx == CRC_RESIDUE) && !err_nx && (idx_cur >= LAST_OK);
          fd_seq   <= seq_nx;
        end else begin
          in_frame <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_seq_track.sv
module rx_seq_track #(
  parameter int SEQ_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             fd_valid,
  input  logic             fd_good,
  input  logic [SEQ_W-1:0] fd_seq,
  output logic             ev_drop,
  output logic [SEQ_W-1:0] drop_amt,
  output logic             ev_repeat,
  output logic             ev_ooo,
  output logic [SEQ_W-1:0] exp_seq
);
  logic init_q;
  logic good_evt, is_match, is_rep, is_ahead;

  always_comb begin
    good_evt  = fd_valid && fd_good;
    is_match  = fd_seq == exp_seq;
    is_rep    = fd_seq == exp_seq - 1'b1;
    is_ahead  = fd_seq > exp_seq;
    drop_amt  = fd_seq - exp_seq;
    ev_repeat = good_evt && init_q && is_rep;
    ev_drop   = good_evt && init_q && !is_rep && is_ahead;
    ev_ooo    = good_evt && init_q && !is_rep && !is_ahead && !is_match;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      init_q  <= 1'b0;
      exp_seq <= '0;
    end else if (good_evt) begin
      if (!init_q) begin
        init_q  <= 1'b1;
        exp_seq <= fd_seq + 1'b1;
      end else if (!is_rep && (is_match || is_ahead)) begin
        exp_seq <= fd_seq + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_sat_ctr.sv
module rx_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] amt,
  output logic [W-1:0] cnt
);
  logic [W:0] sum;
  assign sum = {1'b0, cnt} + {1'b0, amt};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= sum[W] ? '1 : sum[W-1:0];
  end
endmodule

// File: rtl/rx_stat_analyzer.sv
module rx_stat_analyzer
  import rx_stat_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int SEQ_W   = 32,
  parameter int SEQ_OFS = 14,
  parameter int MIN_LEN = 64,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic [7:0]        in_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  logic             fd_valid, fd_good;
  logic [SEQ_W-1:0] fd_seq, drop_amt, exp_seq;
  logic             ev_drop, ev_repeat, ev_ooo;

  logic             inc [NUM_CTR];
  logic [CNT_W-1:0] amt [NUM_CTR];
  logic [CNT_W-1:0] cnt [NUM_CTR];

  rx_frame_parse #(
    .SEQ_W(SEQ_W), .SEQ_OFS(SEQ_OFS), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)
  ) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_err(in_err), .in_data(in_data),
    .fd_valid(fd_valid), .fd_good(fd_good), .fd_seq(fd_seq)
  );

  rx_seq_track #(.SEQ_W(SEQ_W)) u_track (
    .clk(clk), .rst(rst), .clr(clr),
    .fd_valid(fd_valid), .fd_good(fd_good), .fd_seq(fd_seq),
    .ev_drop(ev_drop), .drop_amt(drop_amt), .ev_repeat(ev_repeat),
    .ev_ooo(ev_ooo), .exp_seq(exp_seq)
  );

  always_comb begin
    inc[CTR_TOTAL]   = fd_valid;
    amt[CTR_TOTAL]   = CNT_W'(1);
    inc[CTR_DROP]    = ev_drop;
    amt[CTR_DROP]    = CNT_W'(drop_amt);
    inc[CTR_REPEAT]  = ev_repeat;
    amt[CTR_REPEAT]  = CNT_W'(1);
    inc[CTR_OOO]     = ev_ooo;
    amt[CTR_OOO]     = CNT_W'(1);
    inc[CTR_CORRUPT] = fd_valid && !fd_good;
    amt[CTR_CORRUPT] = CNT_W'(1);
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    rx_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .clr(clr),
      .inc(inc[g]), .amt(amt[g]), .cnt(cnt[g])
    );
  end

  logic [CNT_W-1:0] rd_nx;
  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (rd_addr == ADDR_W'(k)) rd_nx = cnt[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nx;
  end
endmodule

// File: rtl/rx_stat_analyzer_chk.sv
module rx_stat_analyzer_chk
  import rx_stat_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SEQ_W  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              fd_valid,
  input logic              fd_good,
  input logic [SEQ_W-1:0]  exp_seq,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [CNT_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  cnt [NUM_CTR]
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_total_step_r1: assert property (@(posedge clk) disable iff (rst)
    (fd_valid && !clr) |=> (cnt[0] == (($past(cnt[0]) == CMAX) ? CMAX : $past(cnt[0]) + 1'b1)));

  p_total_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!fd_valid && !clr) |=> $stable(cnt[0]));

  p_bad_keeps_exp_r6: assert property (@(posedge clk) disable iff (rst)
    (fd_valid && !fd_good && !clr) |=> $stable(exp_seq));

  p_bad_no_seq_ctr_r6: assert property (@(posedge clk) disable iff (rst)
    (fd_valid && !fd_good && !clr) |=> ($stable(cnt[1]) && $stable(cnt[2]) && $stable(cnt[3])));

  p_drop_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt[1] == CMAX && !clr) |=> (cnt[1] == CMAX));

  p_clear_zero_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt[0] == '0 && cnt[1] == '0 && cnt[2] == '0 && cnt[3] == '0 && cnt[4] == '0));

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_addr >= ADDR_W'(NUM_CTR)) |=> (rd_data == '0));
endmodule

bind rx_stat_analyzer rx_stat_analyzer_chk #(
  .CNT_W(CNT_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .fd_valid(fd_valid), .fd_good(fd_good),
  .exp_seq(exp_seq), .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt)
);

// File: tb/rx_stat_analyzer_tb.sv
`timescale 1ns/1ps
module rx_stat_analyzer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]  in_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  rx_stat_analyzer u_dut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  localparam int K_GOOD = 0, K_BADCRC = 1, K_SHORT = 2, K_ERR = 3;
  localparam int NV = 10;
  localparam logic [31:0] V_SEQ  [NV] = '{32'd100, 32'd101, 32'd105, 32'd105, 32'd103,
                                         32'd106, 32'd110, 32'd110, 32'd106, 32'd107};
  localparam int          V_KIND [NV] = '{K_GOOD, K_GOOD, K_GOOD, K_GOOD, K_GOOD,
                                         K_BADCRC, K_SHORT, K_ERR, K_GOOD, K_GOOD};
  // expected {total, drop, repeat, ooo, corrupted}
  localparam logic [39:0] V_EXP  [NV] = '{
    {8'd1, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd2, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd3, 8'd3, 8'd0, 8'd0, 8'd0},
    {8'd4, 8'd3, 8'd1, 8'd0, 8'd0},
    {8'd5, 8'd3, 8'd1, 8'd1, 8'd0},
    {8'd6, 8'd3, 8'd1, 8'd1, 8'd1},
    {8'd7, 8'd3, 8'd1, 8'd1, 8'd2},
    {8'd8, 8'd3, 8'd1, 8'd1, 8'd3},
    {8'd9, 8'd3, 8'd1, 8'd1, 8'd3},
    {8'd10, 8'd3, 8'd1, 8'd1, 8'd3}};

  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'd0, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ({1'b0, r[31:1]} ^ 32'hEDB88320) : {1'b0, r[31:1]};
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input logic s, input logic e, input logic er);
    @(negedge clk);
    in_valid = 1'b1; in_sof = s; in_eof = e; in_err = er; in_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0; in_data = 8'hA5;
    end
  endtask

  // R12: idle gaps inside frames carry junk data that must not be absorbed.
  task automatic send_frame(input logic [31:0] seq, input int kind);
    logic [7:0]  fb [64];
    logic [31:0] crc;
    int          len;
    len = (kind == K_SHORT) ? 40 : 64;
    for (int i = 0; i < 64; i++) fb[i] = 8'(i * 7 + 3);
    fb[12] = 8'h88; fb[13] = 8'hB5;
    fb[14] = seq[31:24]; fb[15] = seq[23:16]; fb[16] = seq[15:8]; fb[17] = seq[7:0];
    crc = 32'hFFFFFFFF;
    for (int i = 0; i < len - 4; i++) crc = tb_crc(crc, fb[i]);
    crc = ~crc;
    if (kind == K_BADCRC) crc = crc ^ 32'h0000_0100;
    fb[len-4] = crc[7:0]; fb[len-3] = crc[15:8]; fb[len-2] = crc[23:16]; fb[len-1] = crc[31:24];
    for (int i = 0; i < len; i++) begin
      beat(fb[i], i == 0, i == len - 1, (kind == K_ERR) && (i == 20));
      if (i % 9 == 4) idle(1);
    end
    idle(5);
  endtask

  task automatic read_ctr(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R13: all counters zero after reset
    for (int a = 0; a < 5; a++) begin
      read_ctr(3'(a), v); check("R13 reset counter", v, 32'd0);
    end

    // R12: stray beats outside a frame change nothing
    beat(8'h11, 1'b0, 1'b0, 1'b0);
    beat(8'h22, 1'b0, 1'b1, 1'b1);
    idle(5);
    read_ctr(3'd0, v); check("R12 stray beats total", v, 32'd0);
    read_ctr(3'd4, v); check("R12 stray beats corrupted", v, 32'd0);

    // Table walk: R1..R8, R11 (addresses 0..4), R12 (gaps inside frames)
    for (int t = 0; t < NV; t++) begin
      logic [39:0] e;
      send_frame(V_SEQ[t], V_KIND[t]);
      e = V_EXP[t];
      read_ctr(3'd0, v); check($sformatf("R1 total row %0d", t), v, {24'd0, e[39:32]});
      read_ctr(3'd1, v); check($sformatf("R2 R3 drop row %0d", t), v, {24'd0, e[31:24]});
      read_ctr(3'd2, v); check($sformatf("R4 repeat row %0d", t), v, {24'd0, e[23:16]});
      read_ctr(3'd3, v); check($sformatf("R5 ooo row %0d", t), v, {24'd0, e[15:8]});
      read_ctr(3'd4, v); check($sformatf("R6 R7 R8 corrupted row %0d", t), v, {24'd0, e[7:0]});
    end

    // R11: unmapped addresses read zero
    read_ctr(3'd5, v); check("R11 addr 5", v, 32'd0);
    read_ctr(3'd7, v); check("R11 addr 7", v, 32'd0);

    // R10: clear zeroes everything and restarts tracking
    pulse_clear();
    for (int a = 0; a < 5; a++) begin
      read_ctr(3'(a), v); check("R10 cleared counter", v, 32'd0);
    end
    send_frame(32'd5000, K_GOOD);
    read_ctr(3'd1, v); check("R10 R2 first after clear no drop", v, 32'd0);
    send_frame(32'd5000, K_GOOD);
    read_ctr(3'd2, v); check("R10 R4 repeat after re-init", v, 32'd1);

    // R9: drop saturation with large jumps, sequence wraps to zero
    pulse_clear();
    send_frame(32'h0000_0000, K_GOOD);
    send_frame(32'h8000_0000, K_GOOD);
    read_ctr(3'd1, v); check("R3 large drop", v, 32'h7FFF_FFFF);
    send_frame(32'hFFFF_FFFF, K_GOOD);
    read_ctr(3'd1, v); check("R3 drop near limit", v, 32'hFFFF_FFFD);
    send_frame(32'hFFFF_FFFF, K_GOOD);
    read_ctr(3'd2, v); check("R4 repeat across wrap", v, 32'd1);
    read_ctr(3'd1, v); check("R4 wrap repeat no drop", v, 32'hFFFF_FFFD);
    send_frame(32'd10, K_GOOD);
    read_ctr(3'd1, v); check("R9 drop saturates", v, 32'hFFFF_FFFF);
    send_frame(32'd20, K_GOOD);
    read_ctr(3'd1, v); check("R9 drop stays saturated", v, 32'hFFFF_FFFF);
    read_ctr(3'd0, v); check("R1 total after saturation run", v, 32'd6);
    read_ctr(3'd3, v); check("R5 no ooo in saturation run", v, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule